// File: doc/BRIEF.md
# Floating-Point Exception Flag Accumulator

This block sits beside a floating-point unit. It turns the status that the unit reports for each operation into sticky flag bits held in a small control/status register, and it decides whether a floating-point exception must be requested. The unit gives a one-cycle status vector that names the cause of a fault. Invalid-operation causes are split into fine-grained sub-causes, and there are separate overflow, underflow, divide-by-zero and inexact bits.

Many invalid sub-causes fold into one general invalid flag. The two NaN sub-causes also keep flags of their own, and the two infinity-arithmetic sub-causes set an extra infinity flag. One enable bit in the register gates both the capture of flags and the raising of the exception.

When an update is accepted and any flag is set afterwards, the block issues a one-cycle exception request. The request carries the address of the instruction that caused the update. Software reads the register at any time. A write replaces the whole register, which is how flags are cleared.

Top module: `fpflag_accum`

## Requirements
- R1: While `rst` is high at a clock edge, the register `csr_o` becomes all zeros and `fpe_req_o` becomes 0.
- R2: The register layout is bit 0 = enable, bit 1 = overflow, bit 2 = underflow, bit 3 = signalling NaN, bit 4 = quiet NaN, bit 5 = invalid, bit 6 = infinity, bit 7 = divide-by-zero, bit 8 = inexact. A cycle with `csr_we_i` high and no status update makes `csr_o` equal `csr_wdata_i` after that edge.
- R3: When the enable bit is 0 after any write in that cycle, a status update (`st_valid_i` high) changes no flag bit and produces no exception request.
- R4: Status cause bits are [0] signalling NaN, [1] quiet NaN, [2] inf-inf, [3] inf/inf, [4] 0/0, [5] inf*0, [6] invalid conversion, [7] invalid compare, [8] invalid square root. An enabled update with any of bits 0 to 8 set sets the invalid flag (bit 5).
- R5: Cause bit 0 alone also sets the signalling-NaN flag (bit 3), and cause bit 1 alone also sets the quiet-NaN flag (bit 4).
- R6: The infinity flag (bit 6) is set only by cause bits 2 and 3.
- R7: Cause bits [9] overflow, [10] underflow, [11] divide-by-zero and [12] inexact set register bits 1, 2, 7 and 8 respectively. No other cause bit sets these flags.
- R8: Flags are sticky. Without a write, no flag bit goes from 1 to 0.
- R9: An enabled status update after which any of the eight flags is 1 raises `fpe_req_o` for exactly the following cycle. `fpe_pc_o` then equals `prev_pc_i` from the update cycle. Such an update includes one whose cause vector is zero when flags are already set. There is no request in any other case.
- R10: A write and a status update in the same cycle apply the write first. The written enable bit then gates the update, and the new flags are OR-ed over the written flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we_i | input | 1 | Register write strobe |
| csr_wdata_i | input | 9 | Register write value |
| st_valid_i | input | 1 | Status update strobe from the FPU |
| st_cause_i | input | 13 | Per-operation cause bits |
| prev_pc_i | input | ADDR_W | Address of the instruction that produced the status |
| csr_o | output | 9 | Register contents |
| fpe_req_o | output | 1 | One-cycle floating-point exception request |
| fpe_pc_o | output | ADDR_W | Address carried with the request |

## Verification
The hardest situation to reach is a write and a status update in the same cycle. This matters most when the written enable bit differs from the stored one, because the outcome depends on which value gates the update. Directed steps write enable-on with cleared flags together with a fault, and write enable-off together with a fault. The random phase drives write and update strobes independently, so the two collide often and the merge rule is exercised against the bench model. A second hard case is a request raised by earlier sticky flags alone, with an all-zero cause vector. Directed steps reach it by setting flags first and then sending an empty update.

// File: rtl/fpflag_pkg.sv
package fpflag_pkg;

    localparam int CAUSE_W   = 13;
    localparam int NUM_FLAGS = 8;
    localparam int CSR_W     = NUM_FLAGS + 1;

    // cause bit positions
    localparam int C_SNAN  = 0;
    localparam int C_QNAN  = 1;
    localparam int C_ISI   = 2;
    localparam int C_IDI   = 3;
    localparam int C_ZDZ   = 4;
    localparam int C_IMZ   = 5;
    localparam int C_CVT   = 6;
    localparam int C_CMP   = 7;
    localparam int C_SQRT  = 8;
    localparam int C_OVF   = 9;
    localparam int C_UNF   = 10;
    localparam int C_DZ    = 11;
    localparam int C_INEX  = 12;

    // flag index (register bit = index + 1)
    localparam int F_OVF  = 0;
    localparam int F_UNF  = 1;
    localparam int F_SNAN = 2;
    localparam int F_QNAN = 3;
    localparam int F_INV  = 4;
    localparam int F_INF  = 5;
    localparam int F_DZ   = 6;
    localparam int F_INEX = 7;

    typedef struct packed {
        logic [NUM_FLAGS-1:0] flags;
        logic                 en;
    } csr_t;

    // Which cause bits feed each flag.
    function automatic logic [CAUSE_W-1:0] flag_cause_mask(input int idx);
        logic [CAUSE_W-1:0] m;
        m = '0;
        case (idx)
            F_OVF:  m[C_OVF]  = 1'b1;
            F_UNF:  m[C_UNF]  = 1'b1;
            F_SNAN: m[C_SNAN] = 1'b1;
            F_QNAN: m[C_QNAN] = 1'b1;
            F_INV:  m[C_SQRT:C_SNAN] = '1;
            F_INF:  begin m[C_ISI] = 1'b1; m[C_IDI] = 1'b1; end
            F_DZ:   m[C_DZ]   = 1'b1;
            F_INEX: m[C_INEX] = 1'b1;
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/fpflag_cause_map.sv
module fpflag_cause_map
    import fpflag_pkg::*;
(
    input  logic [CAUSE_W-1:0]   cause_i,
    output logic [NUM_FLAGS-1:0] flag_set_o
);

    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
        localparam logic [CAUSE_W-1:0] MASK = flag_cause_mask(k);
        assign flag_set_o[k] = |(cause_i & MASK);
    end

endmodule

// File: rtl/fpflag_csr_reg.sv
module fpflag_csr_reg
    import fpflag_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we_i,
    input  csr_t                 wdata_i,
    input  logic                 upd_i,
    input  logic [NUM_FLAGS-1:0] flag_set_i,
    output csr_t                 csr_q_o,
    output logic                 armed_o,
    output logic [NUM_FLAGS-1:0] post_flags_o
);

    csr_t csr_q;
    csr_t base;
    csr_t nxt;

    // Write lands first; the resulting enable gates the update.
    always_comb begin
        base    = we_i ? wdata_i : csr_q;
        armed_o = upd_i && base.en;
        nxt     = base;
        if (armed_o) begin
            nxt.flags = base.flags | flag_set_i;
        end
        post_flags_o = nxt.flags;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            csr_q <= '0;
        end else begin
            csr_q <= nxt;
        end
    end

    assign csr_q_o = csr_q;

endmodule

// File: rtl/fpflag_raise.sv
module fpflag_raise
    import fpflag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 armed_i,
    input  logic [NUM_FLAGS-1:0] post_flags_i,
    input  logic [ADDR_W-1:0]    pc_i,
    output logic                 req_o,
    output logic [ADDR_W-1:0]    pc_o
);

    logic fire;
    assign fire = armed_i && (|post_flags_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_o <= 1'b0;
            pc_o  <= '0;
        end else begin
            req_o <= fire;
            if (fire) begin
                pc_o <= pc_i;
            end
        end
    end

endmodule

// File: rtl/fpflag_accum.sv
module fpflag_accum
    import fpflag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 csr_we_i,
    input  logic [CSR_W-1:0]     csr_wdata_i,
    input  logic                 st_valid_i,
    input  logic [CAUSE_W-1:0]   st_cause_i,
    input  logic [ADDR_W-1:0]    prev_pc_i,
    output logic [CSR_W-1:0]     csr_o,
    output logic                 fpe_req_o,
    output logic [ADDR_W-1:0]    fpe_pc_o
);

    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] post_flags;
    logic                 armed;
    csr_t                 csr_q;

    fpflag_cause_map u_map (
        .cause_i    (st_cause_i),
        .flag_set_o (flag_set)
    );

    fpflag_csr_reg u_csr (
        .clk          (clk),
        .rst          (rst),
        .we_i         (csr_we_i),
        .wdata_i      (csr_t'(csr_wdata_i)),
        .upd_i        (st_valid_i),
        .flag_set_i   (flag_set),
        .csr_q_o      (csr_q),
        .armed_o      (armed),
        .post_flags_o (post_flags)
    );

    fpflag_raise #(.ADDR_W(ADDR_W)) u_raise (
        .clk          (clk),
        .rst          (rst),
        .armed_i      (armed),
        .post_flags_i (post_flags),
        .pc_i         (prev_pc_i),
        .req_o        (fpe_req_o),
        .pc_o         (fpe_pc_o)
    );

    assign csr_o = csr_q;

endmodule

// File: rtl/fpflag_accum_chk.sv
module fpflag_accum_chk
    import fpflag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 csr_we_i,
    input logic [CSR_W-1:0]     csr_wdata_i,
    input logic                 st_valid_i,
    input logic [CAUSE_W-1:0]   st_cause_i,
    input logic [ADDR_W-1:0]    prev_pc_i,
    input logic [CSR_W-1:0]     csr_o,
    input logic                 fpe_req_o,
    input logic [ADDR_W-1:0]    fpe_pc_o
);

    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (csr_o == '0 && !fpe_req_o));

    // R2
    write_replace_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (csr_we_i && !st_valid_i) |=> csr_o == $past(csr_wdata_i));

    // R3
    disabled_hold_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (!csr_we_i && !csr_o[0]) |=> (csr_o == $past(csr_o) && !fpe_req_o));

    // R8
    sticky_flags_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
        !csr_we_i |=> ((csr_o[CSR_W-1:1] & $past(csr_o[CSR_W-1:1])) == $past(csr_o[CSR_W-1:1])));

    // R9
    raise_addr_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (st_valid_i && !csr_we_i && csr_o[0] && (st_cause_i != '0 || csr_o[CSR_W-1:1] != '0))
        |=> (fpe_req_o && fpe_pc_o == $past(prev_pc_i)));

    // R9
    no_spurious_req_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
        !st_valid_i |=> !fpe_req_o);

endmodule

bind fpflag_accum fpflag_accum_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .csr_we_i    (csr_we_i),
    .csr_wdata_i (csr_wdata_i),
    .st_valid_i  (st_valid_i),
    .st_cause_i  (st_cause_i),
    .prev_pc_i   (prev_pc_i),
    .csr_o       (csr_o),
    .fpe_req_o   (fpe_req_o),
    .fpe_pc_o    (fpe_pc_o)
);

// File: tb/tb_fpflag_accum.sv
module tb_fpflag_accum;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          we;
    logic [8:0]    wdata;
    logic          sv;
    logic [12:0]   cause;
    logic [AW-1:0] pc;
    logic [8:0]    csr;
    logic          req;
    logic [AW-1:0] rpc;

    int n_chk  = 0;
    int n_fail = 0;
    logic [8:0] m_csr;
    bit finished = 0;

    always #4 clk = ~clk;

    fpflag_accum #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .csr_we_i(we), .csr_wdata_i(wdata),
        .st_valid_i(sv), .st_cause_i(cause), .prev_pc_i(pc),
        .csr_o(csr), .fpe_req_o(req), .fpe_pc_o(rpc)
    );

    // Flags in register order bits 8..1: inex, dz, inf, inv, qnan, snan, unf, ovf
    function automatic logic [7:0] map_flags(input logic [12:0] c);
        logic [7:0] f;
        f[0] = c[9];
        f[1] = c[10];
        f[2] = c[0];
        f[3] = c[1];
        f[4] = |c[8:0];
        f[5] = c[2] | c[3];
        f[6] = c[11];
        f[7] = c[12];
        return f;
    endfunction

    task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic w, input logic [8:0] wd,
                        input logic v, input logic [12:0] c, input logic [AW-1:0] p);
        logic [8:0] base;
        logic       e_req;
        we = w; wdata = wd; sv = v; cause = c; pc = p;
        base  = w ? wd : m_csr;
        e_req = 1'b0;
        if (v && base[0]) begin
            base[8:1] = base[8:1] | map_flags(c);
            e_req = (base[8:1] != 8'h0);
        end
        m_csr = base;
        @(posedge clk);
        #2;
        check({tag, " csr"}, AW'(csr), AW'(m_csr));
        check({tag, " req"}, AW'(req), AW'(e_req));
        if (e_req) check({tag, " pc"}, rpc, p);
        we = 1'b0; sv = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 20240611;
        void'($urandom(seed));
        rst = 1'b1; we = 0; wdata = 0; sv = 0; cause = 0; pc = 0;
        m_csr = 9'h0;
        repeat (3) @(posedge clk);
        #2;
        check("R1 csr", AW'(csr), 0);
        check("R1 req", AW'(req), 0);
        rst = 1'b0;

        step("R2 write", 1, 9'h1FF, 0, 0, 0);
        step("R2 clear", 1, 9'h001, 0, 0, 0);

        // each cause alone on a freshly cleared, enabled register
        for (int b = 0; b < 13; b++) begin
            string t;
            t = (b < 2) ? "R5" : (b < 4) ? "R6" : (b < 9) ? "R4" : "R7";
            step("clear", 1, 9'h001, 0, 0, 0);
            step(t, 0, 0, 1, 13'(1) << b, 32'h1000 + 32'(b * 4));
        end

        // sticky accumulation
        step("R8 clr", 1, 9'h001, 0, 0, 0);
        step("R8 a", 0, 0, 1, 13'h0200, 32'hA0);
        step("R8 b", 0, 0, 1, 13'h1000, 32'hA4);
        step("R8 c", 0, 0, 1, 13'h0000, 32'hA8);  // R9 sticky-only raise

        // disabled
        step("R3 off", 1, 9'h000, 0, 0, 0);
        step("R3 upd", 0, 0, 1, 13'h1FFF, 32'hB0);
        step("R3 stale", 1, 9'h0F0, 0, 0, 0);
        step("R3 upd2", 0, 0, 1, 13'h0001, 32'hB4);

        // same-cycle write and update
        step("R10 en", 1, 9'h001, 1, 13'h0200, 32'hC0);
        step("R10 off", 1, 9'h000, 1, 13'h0FFF, 32'hC4);
        step("R10 mix", 1, 9'h101, 1, 13'h0800, 32'hC8);
        step("R9 zero", 1, 9'h001, 1, 13'h0000, 32'hCC);

        for (int i = 0; i < 400; i++) begin
            logic w, v;
            logic [8:0] wd;
            w  = ($urandom % 5) == 0;
            v  = ($urandom % 2) == 0;
            wd = 9'($urandom);
            if (($urandom % 3) != 0) wd[0] = 1'b1;
            if (($urandom % 2) != 0) wd[8:1] = 8'h0;
            step("R8/R9/R10 rnd", w, wd, v, 13'(1) << ($urandom % 14), $urandom);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule